// File: doc/BRIEF.md
# Saturating Command-Pointer Register Front End

This block sits behind the byte layer of a two-wire serial slave. It turns a stream of bus events (start, repeated start, stop, received byte, byte request) into accesses to a generic register file. In a write transaction, the first data byte becomes the command pointer. Each later byte is written to the register the pointer selects.

In a read transaction, each byte request returns the register the pointer selects. The pointer moves up by one after every data byte, whether written or read. It stops moving once it reaches the highest implemented address and stays there; it never wraps to zero.

The pointer survives stop and repeated-start conditions. A master can therefore set the pointer with a short write and then read from that location. Addresses above the last implemented one accept writes but discard them, and they read as zero.

Top module: `cmd_ptr_front`

## Requirements
- R1: The first byte received after a start or repeated start with `ev_rd`=0 loads the pointer (`rf_raddr`) and produces no register write.
- R2: Each later byte of that write transaction produces one `rf_we` pulse in the following cycle, with `rf_waddr` equal to the pointer and `rf_wdata` equal to the byte.
- R3: After each data byte written or read, a pointer below `LAST_ADDR` increases by exactly one.
- R4: A pointer equal to `LAST_ADDR` stays at `LAST_ADDR` after a data byte and never wraps to 0.
- R5: A byte written while the pointer is above `LAST_ADDR` raises no `rf_we`, and the pointer holds its value.
- R6: A byte request while the pointer is above `LAST_ADDR` returns 0x00.
- R7: Stop and repeated-start conditions leave the pointer unchanged, so a new read continues where the last access ended.
- R8: After reset the pointer is 0x00, and `rf_we` and `tx_valid` are low.
- R9: A byte request in a read transaction (`ev_rd`=1 at its start) gives `tx_valid` high for one cycle in the next cycle. `tx_data` then holds the register data at the pointer, or 0x00 per R6.
- R10: A write transaction that carries only the address byte changes the pointer and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition pulse |
| ev_rstart | input | 1 | Repeated start pulse |
| ev_rd | input | 1 | Direction of the starting transaction, 1 = read |
| ev_stop | input | 1 | Stop condition pulse |
| ev_wbyte | input | 1 | Byte received from the master |
| wbyte | input | DATA_W | Received byte value |
| ev_rreq | input | 1 | Master requests a byte |
| tx_data | output | DATA_W | Byte to send, registered |
| tx_valid | output | 1 | tx_data is fresh |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | ADDR_W | Register write address |
| rf_wdata | output | DATA_W | Register write data |
| rf_raddr | output | ADDR_W | Current pointer, drives the register read |
| rf_rdata | input | DATA_W | Combinational register read data |

## Verification
The bench sweeps every starting pointer from 0 to past the top address, writing three bytes from each and reading them back through a fresh address-only write and a repeated start. A design that wraps at the top would overwrite address 0, and a pointer that fails to hold would write to an unimplemented location; the strobe monitor and the readback catch both. A design that clears the pointer on stop would fail the continuation read. A design that leaks the register data at unimplemented addresses would return nonzero bytes where zero is expected.

// File: rtl/cmd_ptr_pkg.sv
package cmd_ptr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WADDR = 2'd1,
    PH_WDATA = 2'd2,
    PH_READ  = 2'd3
  } phase_t;
endpackage

// File: rtl/cmd_ptr_step.sv
module cmd_ptr_step #(
  parameter int ADDR_W    = 8,
  parameter int LAST_ADDR = 'h37
) (
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_next,
  output logic              impl
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

  always_comb begin
    impl     = (ptr <= LAST);
    ptr_next = (ptr < LAST) ? ptr + 1'b1 : ptr;
  end

  always_comb begin
    a_r4_hold_top: assert (ptr != LAST || ptr_next == LAST);
  end
endmodule

// File: rtl/cmd_ptr_wport.sv
module cmd_ptr_wport #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 'h37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we <= req;
      if (req) begin
        waddr <= addr;
        wdata <= data;
      end
    end
  end

  a_r5_no_unimpl_write: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr <= ADDR_W'(LAST_ADDR)));
endmodule

// File: rtl/cmd_ptr_front.sv
module cmd_ptr_front
  import cmd_ptr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 'h37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_rd,
  input  logic              ev_stop,
  input  logic              ev_wbyte,
  input  logic [DATA_W-1:0] wbyte,
  input  logic              ev_rreq,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata
);
  phase_t            phase_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_nxt;
  logic              ptr_impl;
  logic              wr_req;
  logic              any_start;
  logic              load_ptr;

  cmd_ptr_step #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_step (
    .ptr(ptr_q), .ptr_next(ptr_nxt), .impl(ptr_impl)
  );

  always_comb begin
    any_start = ev_start | ev_rstart;
    load_ptr  = !any_start && !ev_stop && ev_wbyte && (phase_q == PH_WADDR);
    wr_req    = !any_start && !ev_stop && ev_wbyte && (phase_q == PH_WDATA) && ptr_impl;
  end

  cmd_ptr_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAST_ADDR(LAST_ADDR)) u_wport (
    .clk(clk), .rst(rst), .req(wr_req), .addr(ptr_q), .data(wbyte[DATA_W-1:0]),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      ptr_q    <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      if (any_start) begin
        phase_q <= ev_rd ? PH_READ : PH_WADDR;
      end else if (ev_stop) begin
        phase_q <= PH_IDLE;
      end else begin
        case (phase_q)
          PH_WADDR: if (ev_wbyte) begin
            ptr_q   <= ADDR_W'(wbyte);
            phase_q <= PH_WDATA;
          end
          PH_WDATA: if (ev_wbyte) ptr_q <= ptr_nxt;
          PH_READ: if (ev_rreq) begin
            tx_data  <= ptr_impl ? rf_rdata : '0;
            tx_valid <= 1'b1;
            ptr_q    <= ptr_nxt;
          end
          default: ;
        endcase
      end
    end
  end

  assign rf_raddr = ptr_q;

  a_r8_reset_ptr: assert property (@(posedge clk) rst |=> (ptr_q == '0 && !tx_valid));
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (!load_ptr && $past(!rst)) |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1));
  a_r7_keep_on_event: assert property (@(posedge clk) disable iff (rst)
    (any_start || ev_stop) |=> $stable(ptr_q));
  a_r9_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_READ && ev_rreq && !any_start && !ev_stop) |=> tx_valid);
  a_r10_no_write_on_load: assert property (@(posedge clk) disable iff (rst)
    load_ptr |=> !rf_we);
endmodule

// File: tb/cmd_ptr_front_bench.sv
module cmd_ptr_front_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int LAST = 'h37;

  logic clk = 0;
  logic rst = 1;
  logic ev_start = 0, ev_rstart = 0, ev_rd = 0, ev_stop = 0, ev_wbyte = 0, ev_rreq = 0;
  logic [DW-1:0] wbyte = 0;
  logic [DW-1:0] tx_data, rf_wdata, rf_rdata;
  logic tx_valid, rf_we;
  logic [AW-1:0] rf_waddr, rf_raddr;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];
  int checks = 0, errors = 0, strobes = 0;

  always #5 clk = ~clk;

  cmd_ptr_front #(.ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST)) u_cmd_ptr_front (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_rd(ev_rd),
    .ev_stop(ev_stop), .ev_wbyte(ev_wbyte), .wbyte(wbyte), .ev_rreq(ev_rreq),
    .tx_data(tx_data), .tx_valid(tx_valid), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = mem[rf_raddr];

  always @(posedge clk) if (rf_we) mem[rf_waddr] <= rf_wdata;

  always @(negedge clk) if (!rst && rf_we) begin
    strobes++;
    if (rf_waddr > LAST) begin
      checks++; errors++;
      $display("FAIL R5: write strobe at addr %0h, expected none above %0h", rf_waddr, LAST);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic rd, input logic rep);
    @(negedge clk); ev_rd = rd; ev_start = !rep; ev_rstart = rep;
    @(negedge clk); ev_start = 0; ev_rstart = 0; ev_rd = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); ev_stop = 1;
    @(negedge clk); ev_stop = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); ev_wbyte = 1; wbyte = b;
    @(negedge clk); ev_wbyte = 0;
  endtask

  task automatic recv(input string req, input int exp);
    @(negedge clk); ev_rreq = 1;
    @(negedge clk); ev_rreq = 0;
    chk("R9 valid", int'(tx_valid), 1);
    chk(req, int'(tx_data), exp);
    @(negedge clk);
    chk("R9 pulse", int'(tx_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i ^ 8'hA5);
      exp_mem[i] = (i <= LAST) ? 8'(i ^ 8'hA5) : 8'h00;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8: reset state
    chk("R8 ptr", int'(rf_raddr), 0);
    chk("R8 we", int'(rf_we), 0);
    chk("R8 valid", int'(tx_valid), 0);
    pulse_start(1, 0);
    recv("R8 read from 0", int'(exp_mem[0]));
    pulse_stop();

    for (int a = 0; a < 'h40; a++) begin
      int p, exp_str, s0;
      p = a; exp_str = 0; s0 = strobes;
      pulse_start(0, 0);
      send(8'(a));
      chk("R1 ptr load", int'(rf_raddr), a);
      chk("R1 no write", strobes - s0, 0);
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d;
        d = 8'((a * 7 + k * 13) ^ 8'h5A);
        send(d);
        if (p <= LAST) begin exp_mem[p] = d; exp_str++; end
        if (p < LAST) p++;
        chk((p == LAST) ? "R4 ptr hold" : ((a > LAST) ? "R5 ptr hold" : "R3 ptr step"),
            int'(rf_raddr), p);
      end
      pulse_stop();
      chk("R2 strobe count", strobes - s0, exp_str);
      chk("R7 ptr after stop", int'(rf_raddr), p);
      // R10: address-only write, then repeated-start read
      s0 = strobes;
      pulse_start(0, 0);
      send(8'(a));
      pulse_start(1, 1);
      chk("R10 no write", strobes - s0, 0);
      chk("R7 ptr after rstart", int'(rf_raddr), a);
      p = a;
      for (int k = 0; k < 3; k++) begin
        recv((p > LAST) ? "R6 zero read" : "R2 readback", int'(exp_mem[p]));
        if (p < LAST) p++;
      end
      pulse_stop();
      pulse_start(1, 0);
      recv("R7 continue after stop", int'(exp_mem[p]));
      pulse_stop();
    end
    chk("R4 no wrap addr0", int'(mem[0]), int'(exp_mem[0]));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule